// File: doc/BRIEF.md
# Boot Signature Checker

This block runs once after every reset and decides whether the application image in the first flash page may be started. It walks the whole page through a synchronous read port, one word per cycle. It also keeps a 32-bit wrapping sum of every word except the signature word at byte offset 0x14. The signature word itself is captured separately.

When the walk ends, the captured signature is compared against two accepted values:

- a fixed magic constant, 0x27011970;
- the computed sum.

If either value matches, `run_user` is raised. Otherwise `enter_download` is raised, so the device stays in its loader instead of starting unverified code. `done` marks that the verdict is valid, and the verdict holds until the next reset.

The controller has five states:

- **IDLE**: one cycle after reset release. It clears the walker and the accumulator. Transition *start*: IDLE to READ.
- **READ**: issues one read per cycle to byte addresses 0, 4, 8 and so on. Transition *last_issued*: READ to FLUSH once the final word address has been issued.
- **FLUSH**: absorbs the last word, which comes back one cycle after it was issued. Transition *drained*: FLUSH to COMPARE.
- **COMPARE**: evaluates the match. Transition *decide*: COMPARE to DONE, registering the verdict.
- **DONE**: holds the verdict. It is left only by reset.

Top module: `bsc_boot_check`

## Requirements
- R1: While `rst_n` is low, `done`, `run_user`, `enter_download` and `rd_en` are all 0.
- R2: After reset release, `rd_en` is high for exactly PAGE_BYTES/4 consecutive cycles. `rd_addr` starts at 0 and rises by 4 each cycle, and `rd_en` stays low afterwards until the next reset.
- R3: The checksum is the 32-bit sum, modulo 2^32, of every page word except the word at byte 0x14 (word index 5). `rd_data` is taken as the word for the address issued in the previous cycle.
- R4: A signature word equal to 0x27011970 gives `run_user`=1 and `enter_download`=0.
- R5: A signature word equal to the checksum of R3 gives `run_user`=1 and `enter_download`=0.
- R6: A signature word matching neither value gives `enter_download`=1 and `run_user`=0.
- R7: Count rising edges from the first rising edge after reset release. `done` rises at edge PAGE_BYTES/4 + 3 and is 0 before it.
- R8: `run_user` and `enter_download` are never both 1. Both are 0 while `done` is 0, and exactly one is 1 while `done` is 1.
- R9: Once `done` is 1, the three outputs stay unchanged until reset, whatever `rd_data` or the flash contents do.
- R10: A reset in the middle of a walk abandons it. The next walk starts again from address 0 and judges the page afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | output | 1 | Flash read strobe, one word per cycle |
| rd_addr | output | ADDR_W | Byte address of the word being read |
| rd_data | input | 32 | Read data, valid one cycle after the strobe |
| done | output | 1 | Verdict valid |
| run_user | output | 1 | Page accepted, start application |
| enter_download | output | 1 | Page rejected, stay in loader |

## Verification
The bench builds the block with PAGE_BYTES = 64, a page of 16 words. Each walk is therefore short enough to repeat for many page images and reset scenarios, while the signature word still sits in the middle of the page with summed words on both sides of it. Page fills include an all-ones pattern, so the sum wraps past 2^32 many times, and one fill makes sum and signature differ by exactly one. The completion edge (16 + 3) is checked to the exact cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam logic [31:0] BSC_MAGIC    = 32'h2701_1970;
    localparam int          BSC_SIG_BYTE = 'h14;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_FLUSH,
        S_COMPARE,
        S_DONE
    } bsc_state_e;
endpackage

// File: rtl/bsc_walker.sv
module bsc_walker #(
    parameter int WORDS = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (step && !last) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/bsc_accum.sv
module bsc_accum #(
    parameter int IDX_W   = 7,
    parameter int SIG_IDX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vld,
    input  logic [IDX_W-1:0] vidx,
    input  logic [31:0]      data,
    output logic [31:0]      sum,
    output logic [31:0]      sig
);
    localparam logic [IDX_W-1:0] SIG_AT = IDX_W'(SIG_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum <= '0;
            sig <= '0;
        end else if (vld) begin
            if (vidx == SIG_AT) begin
                sig <= data;
            end else begin
                sum <= sum + data;
            end
        end
    end
endmodule

// File: rtl/bsc_judge.sv
module bsc_judge #(
    parameter logic [31:0] MAGIC = 32'h2701_1970
) (
    input  logic [31:0] sig,
    input  logic [31:0] sum,
    output logic        pass
);
    always_comb begin
        pass = (sig == MAGIC) || (sig == sum);
    end
endmodule

// File: rtl/bsc_boot_check.sv
module bsc_boot_check
    import bsc_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int ADDR_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output logic              done,
    output logic              run_user,
    output logic              enter_download
);
    localparam int WORDS   = PAGE_BYTES / 4;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int SIG_IDX = BSC_SIG_BYTE / 4;

    bsc_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic              vld_q;
    logic [IDX_W-1:0]  vidx_q;
    logic [31:0]       sum, sig;
    logic              pass;
    logic              clr;

    assign clr     = (state == S_IDLE);
    assign rd_en   = (state == S_READ);
    assign rd_addr = {idx, 2'b00};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    state_nx = S_READ;                       // start
            S_READ:    if (last) state_nx = S_FLUSH;            // last_issued
            S_FLUSH:   state_nx = S_COMPARE;                    // drained
            S_COMPARE: state_nx = S_DONE;                       // decide
            S_DONE:    state_nx = S_DONE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // read return tracking: data arrives one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            vidx_q <= '0;
        end else begin
            vld_q  <= rd_en;
            vidx_q <= idx;
        end
    end

    bsc_walker #(.WORDS(WORDS), .IDX_W(IDX_W)) u_walker (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (rd_en),
        .idx  (idx),
        .last (last)
    );

    bsc_accum #(.IDX_W(IDX_W), .SIG_IDX(SIG_IDX)) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .vld  (vld_q),
        .vidx (vidx_q),
        .data (rd_data),
        .sum  (sum),
        .sig  (sig)
    );

    bsc_judge #(.MAGIC(BSC_MAGIC)) u_judge (
        .sig (sig),
        .sum (sum),
        .pass(pass)
    );

    // output register: verdict taken once, held until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done           <= 1'b0;
            run_user       <= 1'b0;
            enter_download <= 1'b0;
        end else if (state == S_COMPARE) begin
            done           <= 1'b1;
            run_user       <= pass;
            enter_download <= !pass;
        end
    end
endmodule

// File: rtl/bsc_boot_check_sva.sv
module bsc_boot_check_sva #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              run_user,
    input logic              enter_download
);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_user && enter_download));

    a_r8_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!run_user && !enter_download));

    a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_user ^ enter_download));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(run_user) && $stable(enter_download)));

    a_r9_no_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);

    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (rd_addr == '0));

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(4)));
endmodule

bind bsc_boot_check bsc_boot_check_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .done          (done),
    .run_user      (run_user),
    .enter_download(enter_download)
);

// File: tb/bsc_boot_check_tb.sv
module bsc_boot_check_tb;
    localparam int PAGE_BYTES = 64;
    localparam int ADDR_W     = $clog2(PAGE_BYTES);
    localparam int WORDS      = PAGE_BYTES / 4;
    localparam int SIG_IDX    = 5;
    localparam logic [31:0] MAGIC = 32'h2701_1970;

    // vector: {expect_run, kind[1:0], seed[31:0]}
    // kind 0: sig = magic, 1: sig = sum, 2: sig = sum + 1, 3: sig = magic ^ 1
    localparam int NVEC = 8;
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 32'h0000_0000},
        {1'b1, 2'd1, 32'h1234_5678},
        {1'b0, 2'd2, 32'h1234_5678},
        {1'b0, 2'd3, 32'h0BAD_F00D},
        {1'b1, 2'd1, 32'hFFFF_FFFF},
        {1'b1, 2'd0, 32'hDEAD_BEEF},
        {1'b0, 2'd2, 32'hFFFF_FFFF},
        {1'b1, 2'd1, 32'h0000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [31:0]       rd_data;
    logic              done, run_user, enter_download;

    logic [31:0] mem [WORDS];
    int n_checks = 0;
    int n_fail   = 0;
    int rd_count = 0;
    int addr_err = 0;
    int exp_addr = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    bsc_boot_check #(.PAGE_BYTES(PAGE_BYTES)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .done          (done),
        .run_user      (run_user),
        .enter_download(enter_download)
    );

    // flash model, one cycle latency
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[ADDR_W-1:2]];
    end

    // read monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_count <= 0;
            exp_addr <= 0;
        end else if (rd_en) begin
            if (int'(rd_addr) != exp_addr) addr_err <= addr_err + 1;
            exp_addr <= exp_addr + 4;
            rd_count <= rd_count + 1;
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] page_sum();
        logic [31:0] s = '0;
        for (int i = 0; i < WORDS; i++) if (i != SIG_IDX) s += mem[i];
        return s;
    endfunction

    task automatic fill(input logic [31:0] seed, input logic [1:0] kind);
        logic [31:0] s;
        for (int i = 0; i < WORDS; i++)
            mem[i] = (seed == 32'hFFFF_FFFF) ? seed : (seed * (i + 1)) ^ (32'h0101_0101 * i);
        s = page_sum();
        unique case (kind)
            2'd0: mem[SIG_IDX] = MAGIC;
            2'd1: mem[SIG_IDX] = s;
            2'd2: mem[SIG_IDX] = s + 1;
            2'd3: mem[SIG_IDX] = MAGIC ^ 32'h1;
        endcase
    endtask

    // reset pulse then walk; done checked at exact edge (R7)
    task automatic walk(input bit exp_run, input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!done && !run_user && !enter_download && !rd_en, "R1 reset outputs",
              {done, run_user, enter_download, rd_en}, 0);
        rst_n = 1'b1;
        repeat (WORDS + 2) @(posedge clk);
        #1;
        check(done == 1'b0, "R7 done not early", done, 0);
        @(posedge clk);
        #1;
        check(done == 1'b1, "R7 done on edge N+3", done, 1);
        check(run_user == exp_run, {tag, " run_user"}, run_user, exp_run);
        check(enter_download == !exp_run, {tag, " enter_download"}, enter_download, !exp_run);
        check(rd_count == WORDS && addr_err == 0, "R2 read sequence", rd_count, WORDS);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
        // vector table
        for (int v = 0; v < NVEC; v++) begin
            fill(VEC[v][31:0], VEC[v][33:32]);
            case (VEC[v][33:32])
                2'd0: walk(VEC[v][34], "R4 magic");
                2'd1: walk(VEC[v][34], "R5 R3 checksum");
                default: walk(VEC[v][34], "R6 mismatch");
            endcase
        end

        // R9: verdict holds while flash contents change
        fill(32'h5555_AAAA, 2'd1);
        walk(1'b1, "R5 pre-hold");
        for (int i = 0; i < WORDS; i++) mem[i] = 32'hCAFE_0000 + i;
        repeat (30) @(posedge clk);
        #1;
        check(done && run_user && !enter_download, "R9 verdict held",
              {done, run_user, enter_download}, 3'b110);
        check(rd_count == WORDS, "R9 no further reads", rd_count, WORDS);

        // R10: reset mid-walk, then rejudged page
        fill(32'h7777_1111, 2'd3);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        fill(32'h7777_1111, 2'd1);
        walk(1'b1, "R10 restarted walk");

        // R3: signature word excluded; sum including it must not be accepted
        fill(32'h0000_1000, 2'd1);
        mem[SIG_IDX] = page_sum() + mem[SIG_IDX];
        walk(1'b0, "R3 R6 sig counted");

        finish_run();
    end
endmodule